// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces data-memory addresses for a signal-processing datapath from a small file of pointer registers, so that address arithmetic never costs an instruction on the datapath. Each access strobe selects one pointer, a signed step, an update mode and one of two buffer-size slots. The block emits an address and writes the updated pointer back in the same clock. Pre-modify emits the updated pointer. Post-modify emits the pointer as it stood and then advances it.

Three update rules are built in. Linear stepping adds the step across the whole pointer. Circular stepping wraps inside a buffer whose size is a power of two and whose start is aligned to that size. Only the low field of the pointer moves, so no end-of-buffer compare is needed, and the same rule serves delay lines and coefficient tables. Bit-reversed stepping propagates the carry from the top of the low field toward its bottom, which walks a radix-2 FFT data set in reordered sequence. Two size slots let two circular buffers of different lengths be in use across the pointers at once.

Top module: `agu_top`

## Requirements
- R1: With post-modify (`acc_pre`=0), an access strobe emits the selected pointer's current value on `addr_out` and stores the updated value in the pointer. `addr_out` and `addr_vld` are registered and change at the clock edge that samples the strobe. `addr_vld` is 0 after any edge without a strobe.
- R2: With pre-modify (`acc_pre`=1), an access strobe emits the updated pointer value, and that value is also what the pointer holds afterwards.
- R3: In linear mode (`acc_mode`=2'b00, and also 2'b11), the update is pointer plus step modulo 2^AW, with the step taken as two's complement, so negative steps decrement.
- R4: In circular mode (`acc_mode`=2'b01) with slot size 2^L, only the low L bits of the pointer are replaced, by (low bits + step) mod 2^L. The upper bits are unchanged.
- R5: In bit-reversed mode (`acc_mode`=2'b10) with slot size 2^L, the low L bits advance by the step using a carry that runs from bit L-1 toward bit 0. The upper bits are unchanged. With L=3, step 4 and start 0, successive emitted low fields are 0,4,2,6,1,5,3,7 and then 0 again.
- R6: There are two size slots, and `acc_slot` picks which one an access uses. A slot's log2 size is written with `sz_we`/`sz_slot`/`sz_log`, and a written value above AW acts as AW.
- R7: `ld_en` writes `ld_val` into pointer `ld_idx`. If an access hits the same pointer in the same cycle, the load wins for the stored value, and the emitted address is still computed from the old pointer.
- R8: A pointer changes only in a cycle with an access strobe or a load addressed to it.
- R9: After reset, all pointers and both size slots are 0, and `addr_out` and `addr_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_idx | input | IW | Pointer selected for the access |
| acc_mode | input | 2 | Update rule: 00 linear, 01 circular, 10 bit-reversed, 11 linear |
| acc_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| acc_slot | input | 1 | Size slot used by the access |
| acc_step | input | AW | Signed step |
| ld_en | input | 1 | Pointer load strobe |
| ld_idx | input | IW | Pointer written by a load |
| ld_val | input | AW | Value loaded |
| sz_we | input | 1 | Size slot write strobe |
| sz_slot | input | 1 | Size slot written |
| sz_log | input | LW | log2 of the buffer size |
| addr_out | output | AW | Emitted address |
| addr_vld | output | 1 | `addr_out` was produced by the previous edge's access |

## Verification
The assertions assume that a load and an access aimed at the same pointer in the same cycle are the only collision. The checks that compare pointer contents exclude that case, because there the load value replaces the update. They also assume that the buffers used in circular and bit-reversed mode start at a multiple of their size, so the upper field is meaningful. The stimulus loads every pointer with an aligned base before it walks that pointer. It changes the slot sizes only between groups of accesses, and it drives every input half a cycle away from the sampling edge.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    UPD_LINEAR = 2'b00,
    UPD_CIRC   = 2'b01,
    UPD_BREV   = 2'b10,
    UPD_LIN2   = 2'b11
  } upd_mode_e;
endpackage

// File: rtl/agu_size_cfg.sv
module agu_size_cfg #(
  parameter int AW = 16,
  localparam int LW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wslot,
  input  logic [LW-1:0] wlog,
  input  logic          rslot,
  output logic [LW-1:0] rlog
);
  logic [LW-1:0] slot_q [2];

  // store already saturated so readers see a legal width
  function automatic logic [LW-1:0] sat_log(input logic [LW-1:0] v);
    if (int'(v) > AW) return LW'(AW);
    return v;
  endfunction

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (we && (wslot == s[0])) slot_q[s] <= sat_log(wlog);
    end
  end

  assign rlog = slot_q[rslot];

  p_slot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rlog) <= AW);
endmodule

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int IW  = $clog2(NPTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [IW-1:0]            ld_idx,
  input  logic [AW-1:0]            ld_val,
  input  logic                     up_en,
  input  logic [IW-1:0]            up_idx,
  input  logic [AW-1:0]            up_val,
  output logic [NPTR-1:0][AW-1:0]  ptr_all
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic ld_hit, up_hit;
    assign ld_hit = ld_en && (ld_idx == IW'(i));
    assign up_hit = up_en && (up_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)      ptr_all[i] <= '0;
      else if (ld_hit) ptr_all[i] <= ld_val;   // load has priority
      else if (up_hit) ptr_all[i] <= up_val;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !up_en) |=> $stable(ptr_all));
endmodule

// File: rtl/agu_step_calc.sv
module agu_step_calc
  import agu_pkg::*;
#(
  parameter int AW = 16,
  localparam int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  upd_mode_e     mode,
  input  logic [LW-1:0] lg,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] fld_mask
);
  function automatic logic [AW-1:0] low_mask(input logic [LW-1:0] l);
    logic [AW:0] m;
    m = ({{AW{1'b0}}, 1'b1} << l) - {{AW{1'b0}}, 1'b1};
    return m[AW-1:0];
  endfunction

  // reverse the low l bits of x; bits above l come out as zero
  function automatic logic [AW-1:0] rev_low(input logic [AW-1:0] x, input logic [LW-1:0] l);
    logic [AW-1:0] full;
    for (int i = 0; i < AW; i++) full[i] = x[AW-1-i];
    return full >> (AW - int'(l));
  endfunction

  function automatic logic [AW-1:0] circ_step(input logic [AW-1:0] p, input logic [AW-1:0] s,
                                              input logic [AW-1:0] m);
    return (p & ~m) | ((p + s) & m);
  endfunction

  function automatic logic [AW-1:0] brev_step(input logic [AW-1:0] p, input logic [AW-1:0] s,
                                              input logic [LW-1:0] l, input logic [AW-1:0] m);
    logic [AW-1:0] sum;
    sum = rev_low(rev_low(p, l) + rev_low(s, l), l);
    return (p & ~m) | (sum & m);
  endfunction

  assign fld_mask = low_mask(lg);

  always_comb begin
    unique case (mode)
      UPD_CIRC: nxt = circ_step(cur, step, fld_mask);
      UPD_BREV: nxt = brev_step(cur, step, lg, fld_mask);
      default:  nxt = cur + step;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int IW  = $clog2(NPTR),
  localparam int LW  = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic [IW-1:0] acc_idx,
  input  logic [1:0]    acc_mode,
  input  logic          acc_pre,
  input  logic          acc_slot,
  input  logic [AW-1:0] acc_step,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_val,
  input  logic          sz_we,
  input  logic          sz_slot,
  input  logic [LW-1:0] sz_log,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  logic [NPTR-1:0][AW-1:0] ptr_all;
  logic [AW-1:0]           cur_ptr, nxt_ptr, fld_mask;
  logic [LW-1:0]           acc_log;
  logic                    ld_clash;
  upd_mode_e               mode_e;

  assign mode_e   = upd_mode_e'(acc_mode);
  assign cur_ptr  = ptr_all[acc_idx];
  assign ld_clash = ld_en && (ld_idx == acc_idx);

  agu_size_cfg #(.AW(AW)) u_size (
    .clk(clk), .rst_n(rst_n), .we(sz_we), .wslot(sz_slot), .wlog(sz_log),
    .rslot(acc_slot), .rlog(acc_log)
  );

  agu_step_calc #(.AW(AW)) u_calc (
    .cur(cur_ptr), .step(acc_step), .mode(mode_e), .lg(acc_log),
    .nxt(nxt_ptr), .fld_mask(fld_mask)
  );

  agu_ptr_file #(.AW(AW), .NPTR(NPTR)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .up_en(acc_en), .up_idx(acc_idx), .up_val(nxt_ptr), .ptr_all(ptr_all)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_en;
      if (acc_en) addr_out <= acc_pre ? nxt_ptr : cur_ptr;
    end
  end

  p_post_emit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_pre) |=> (addr_out == $past(cur_ptr)));

  p_pre_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_pre && !ld_clash) |=> (addr_out == ptr_all[$past(acc_idx)]));

  p_circ_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b01 && !ld_clash) |=>
      ((ptr_all[$past(acc_idx)] & ~$past(fld_mask)) == ($past(cur_ptr) & ~$past(fld_mask))));

  p_brev_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b10 && !ld_clash) |=>
      ((ptr_all[$past(acc_idx)] & ~$past(fld_mask)) == ($past(cur_ptr) & ~$past(fld_mask))));

  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (ptr_all[$past(ld_idx)] == $past(ld_val)));

  p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !addr_vld);
endmodule

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb;
  localparam int AW = 16;
  localparam int NPTR = 4;
  localparam int IW = $clog2(NPTR);
  localparam int LW = $clog2(AW + 1);
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 0, acc_pre = 0, acc_slot = 0, ld_en = 0, sz_we = 0, sz_slot = 0;
  logic [IW-1:0] acc_idx = '0, ld_idx = '0;
  logic [1:0] acc_mode = '0;
  logic [AW-1:0] acc_step = '0, ld_val = '0;
  logic [LW-1:0] sz_log = '0;
  logic [AW-1:0] addr_out;
  logic addr_vld;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  agu_top #(.AW(AW), .NPTR(NPTR)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_idx(acc_idx), .acc_mode(acc_mode),
    .acc_pre(acc_pre), .acc_slot(acc_slot), .acc_step(acc_step), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_val(ld_val), .sz_we(sz_we), .sz_slot(sz_slot), .sz_log(sz_log),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  // {idx, mode, pre, slot, step, expected emitted address}
  localparam logic [37:0] VEC [NV] = '{
    // R3 linear, p0 = 0x0100
    {2'd0, 2'b00, 1'b0, 1'b0, 16'h0003, 16'h0100},
    {2'd0, 2'b00, 1'b0, 1'b0, 16'hFFFB, 16'h0103},
    {2'd0, 2'b11, 1'b1, 1'b0, 16'h0002, 16'h0100},
    // R4 circular, p1 = 0x0235, slot0 size 8, slot1 size 4 (R6)
    {2'd1, 2'b01, 1'b0, 1'b0, 16'h0002, 16'h0235},
    {2'd1, 2'b01, 1'b0, 1'b0, 16'h0002, 16'h0237},
    {2'd1, 2'b01, 1'b1, 1'b0, 16'hFFFD, 16'h0236},
    {2'd1, 2'b01, 1'b1, 1'b1, 16'h0003, 16'h0235},
    // R5 bit-reversed, p2 = 0x0040, 8 points
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0040},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0044},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0042},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0046},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0041},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0045},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0043},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0047},
    {2'd2, 2'b10, 1'b0, 1'b0, 16'h0004, 16'h0040},
    // R5 with R2 pre-modify, p3 = 0, 4 points on slot1
    {2'd3, 2'b10, 1'b1, 1'b1, 16'h0002, 16'h0002},
    {2'd3, 2'b10, 1'b1, 1'b1, 16'h0002, 16'h0001},
    {2'd3, 2'b10, 1'b1, 1'b1, 16'h0002, 16'h0003},
    {2'd3, 2'b10, 1'b1, 1'b1, 16'h0002, 16'h0000}
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [IW-1:0] i, input logic [AW-1:0] v);
    @(negedge clk); ld_en = 1; ld_idx = i; ld_val = v;
    @(posedge clk); #1; ld_en = 0;
  endtask

  task automatic set_size(input logic s, input logic [LW-1:0] l);
    @(negedge clk); sz_we = 1; sz_slot = s; sz_log = l;
    @(posedge clk); #1; sz_we = 0;
  endtask

  task automatic access(input logic [IW-1:0] i, input logic [1:0] m, input logic p,
                        input logic s, input logic [AW-1:0] st);
    @(negedge clk);
    acc_en = 1; acc_idx = i; acc_mode = m; acc_pre = p; acc_slot = s; acc_step = st;
    @(posedge clk); #1; acc_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 addr", addr_out, '0);
    check("R9 vld", {15'd0, addr_vld}, 16'd0);
    @(negedge clk); rst_n = 1;

    set_size(1'b0, LW'(3));
    set_size(1'b1, LW'(2));
    load(2'd0, 16'h0100);
    load(2'd1, 16'h0235);
    load(2'd2, 16'h0040);
    load(2'd3, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      logic [37:0] v;
      string tag;
      v = VEC[k];
      access(v[37:36], v[35:34], v[33], v[32], v[31:16]);
      case (v[35:34])
        2'b01:   tag = "R4";
        2'b10:   tag = "R5";
        default: tag = "R3";
      endcase
      check({tag, v[33] ? " R2 pre" : " R1 post"}, addr_out, v[15:0]);
    end

    // R1: valid drops after an edge without a strobe
    @(posedge clk); #1;
    check("R1 vld idle", {15'd0, addr_vld}, 16'd0);

    // R8: idle cycles leave p0 at 0x0100
    repeat (4) @(posedge clk);
    access(2'd0, 2'b00, 1'b0, 1'b0, 16'h0000);
    check("R8 hold", addr_out, 16'h0100);

    // R7: load collides with access on p0
    @(negedge clk);
    ld_en = 1; ld_idx = 2'd0; ld_val = 16'h0500;
    acc_en = 1; acc_idx = 2'd0; acc_mode = 2'b00; acc_pre = 0; acc_step = 16'h0001;
    @(posedge clk); #1; ld_en = 0; acc_en = 0;
    check("R7 old emit", addr_out, 16'h0100);
    access(2'd0, 2'b00, 1'b0, 1'b0, 16'h0000);
    check("R7 load wins", addr_out, 16'h0500);

    // R6: oversize log saturates to AW, circular over the whole pointer
    set_size(1'b1, LW'(31));
    access(2'd0, 2'b01, 1'b0, 1'b1, 16'hFFFF);
    check("R6 sat emit", addr_out, 16'h0500);
    access(2'd0, 2'b00, 1'b0, 1'b0, 16'h0000);
    check("R6 sat wrap", addr_out, 16'h04FF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule